// File: doc/BRIEF.md
# Inter-Task Register Forwarding Ring

This block carries register values between tasks that run side by side on a ring of processing units. Each unit runs one task at a time, and tasks are ordered around the ring. A value made by one task must reach every younger task, and a younger task must not read a register before the value from the older tasks has reached it. Each unit keeps, per register, a ready bit and the value that arrived from its predecessor. A read port tells the execution logic whether a register may be consumed yet.

At task start a unit is given a create mask, which lists the registers the task may write. Registers outside that mask are relayed to the next unit as soon as they arrive. Registers inside the mask are held. They go on only when the task performs its final write of that register, marked by a forward flag, or when the task releases the register without writing it. A release sends on the value that came in from the older tasks.

Every unit drives one ring link, which carries at most one message per cycle, so one hop costs one cycle. A message carries the register number, the data and the number of the unit it came from. A message is never delivered back to the unit that made it. A squash wipes a unit's state. The compiler analysis that builds the masks and the execution datapath are outside this block.

Top module: `fwd_ring`

## Requirements
- R1: After reset every ready bit is 0 and no unit drives a valid ring message.
- R2: Task start on a unit replaces its create mask. It clears every ready bit of that unit except those set in the keep mask, which stay ready and keep their stored value.
- R3: `rd_ok` of a unit is 1 exactly when the ready bit of the register on its `rd_reg` is set, so a consumer stalls until the value has arrived.
- R4: A write with `wr_fwd` = 1 to a register in the unit's create mask puts a message (register, data, source = own unit number) on the unit's link in the next cycle. One cycle later the successor's ready bit for that register is set. A write with `wr_fwd` = 0 sends nothing.
- R5: A message for a register outside the receiver's create mask is relayed on the receiver's link in the next cycle, keeping its data and source. A unit whose successor is the source does not relay it, so the source never receives its own value.
- R6: A message for a register inside the receiver's create mask sets the ready bit and stores the data, but is not relayed.
- R7: A release of a register in the create mask sends the stored incoming value with source = own unit. If that value has not yet arrived, nothing is sent, and the message goes out in the cycle after the value arrives.
- R8: A unit sends at most one message per cycle. When several are pending, the lowest register number goes first.
- R9: A squash clears the unit's ready bits, create mask, pending releases and unsent messages. A message arriving in the same cycle is dropped.
- R10: A forward write or a release naming a register outside the create mask sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_vld | input | NUM_UNITS | Task start, one bit per unit |
| start_create | input | NUM_UNITS*NUM_REGS | Create mask per unit, taken at start |
| start_keep | input | NUM_UNITS*NUM_REGS | Ready bits kept at start, per unit |
| wr_vld | input | NUM_UNITS | Register write event per unit |
| wr_fwd | input | NUM_UNITS | Write is the task's final write of that register |
| wr_reg | input | NUM_UNITS*RW | Written register number per unit |
| wr_data | input | NUM_UNITS*DATA_W | Written value per unit |
| rel_vld | input | NUM_UNITS | Release event per unit |
| rel_reg | input | NUM_UNITS*RW | Released register number per unit |
| squash | input | NUM_UNITS | Squash per unit |
| rd_reg | input | NUM_UNITS*RW | Register a consumer wants to read, per unit |
| rd_ok | output | NUM_UNITS | Value for rd_reg has arrived |
| ring_vld | output | NUM_UNITS | Link of each unit carries a message |
| ring_reg | output | NUM_UNITS*RW | Register number on each link |
| ring_data | output | NUM_UNITS*DATA_W | Data on each link |
| ring_src | output | NUM_UNITS*UW | Originating unit on each link |
| reg_ready | output | NUM_UNITS*NUM_REGS | Incoming-ready bits per unit |

RW is the register-number width and UW the unit-number width, both derived from the parameters.

## Verification
The assertions check four things on every cycle: the cleared state after reset, the wipe after a squash, that a valid link message sets the successor's ready bit one cycle later, and that no link ever carries a message addressed back to its source. They also check that a start leaves no ready bit set outside the keep mask. Only the bench's scenarios can show that the right data reaches the right unit and where a relay chain stops. The same holds for holding a created register until release, for a release waiting on a late arrival, and for the lowest-first order when several messages are pending.

// File: rtl/fwd_ring_pkg.sv
package fwd_ring_pkg;
  // Successor position of a unit on the one-way ring.
  function automatic int ring_next(input int unit, input int units);
    return (unit + 1) % units;
  endfunction

  // Predecessor position of a unit on the one-way ring.
  function automatic int ring_prev(input int unit, input int units);
    return (unit + units - 1) % units;
  endfunction

  // Index width that stays at least one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fwd_pick.sv
// Fixed-priority picker: lowest set request wins.
module fwd_pick #(
  parameter int N  = 8,
  localparam int IW = fwd_ring_pkg::idx_w(N)
) (
  input  logic [N-1:0]  req,
  output logic          vld,
  output logic [IW-1:0] idx
);
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        vld = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/fwd_slot.sv
// State of one register inside one unit: incoming value, ready bit,
// create-mask bit, pending send and waiting release.
module fwd_slot #(
  parameter int DATA_W  = 16,
  parameter int UNIT_W  = 2,
  parameter int UNIT_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              squash,
  input  logic              start_vld,
  input  logic              start_create,
  input  logic              start_keep,
  input  logic              hit_arr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic [UNIT_W-1:0] arr_src,
  input  logic              arr_pass_ok,
  input  logic              hit_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hit_rel,
  input  logic              sent,
  output logic              rdy_o,
  output logic              pend_o,
  output logic [DATA_W-1:0] sval_o,
  output logic [UNIT_W-1:0] ssrc_o
);
  logic              cre_q, rdy_q, pend_q, wait_q;
  logic [DATA_W-1:0] ival_q, sval_q;
  logic [UNIT_W-1:0] ssrc_q;

  logic              cre_nx, rdy_base, wait_base, have_in;
  logic              own_wr, own_rel, late_rel, relay;
  logic [DATA_W-1:0] in_now;

  always_comb begin
    cre_nx    = start_vld ? start_create : cre_q;
    rdy_base  = start_vld ? (rdy_q & start_keep) : rdy_q;
    wait_base = start_vld ? 1'b0 : wait_q;
    have_in   = rdy_base | hit_arr;
    in_now    = hit_arr ? arr_data : ival_q;
    own_wr    = hit_wr & cre_nx;
    own_rel   = hit_rel & cre_nx;
    late_rel  = hit_arr & cre_nx & wait_base;
    relay     = hit_arr & ~cre_nx & arr_pass_ok;
  end

  always_ff @(posedge clk) begin
    if (rst || squash) begin
      cre_q  <= 1'b0;
      rdy_q  <= 1'b0;
      pend_q <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      cre_q <= cre_nx;
      rdy_q <= have_in;
      if (own_wr || (own_rel && have_in) || late_rel) begin
        pend_q <= 1'b1;
        wait_q <= 1'b0;
      end else if (own_rel) begin
        pend_q <= pend_q & ~sent;
        wait_q <= 1'b1;
      end else if (relay) begin
        pend_q <= 1'b1;
        wait_q <= wait_base;
      end else begin
        pend_q <= pend_q & ~sent;
        wait_q <= wait_base;
      end
    end
  end

  // Data storage carries no reset.
  always_ff @(posedge clk) begin
    if (hit_arr) ival_q <= arr_data;
    if (own_wr) begin
      sval_q <= wr_data;
      ssrc_q <= UNIT_W'(UNIT_ID);
    end else if (own_rel && have_in) begin
      sval_q <= in_now;
      ssrc_q <= UNIT_W'(UNIT_ID);
    end else if (late_rel) begin
      sval_q <= arr_data;
      ssrc_q <= UNIT_W'(UNIT_ID);
    end else if (relay) begin
      sval_q <= arr_data;
      ssrc_q <= arr_src;
    end
  end

  assign rdy_o  = rdy_q;
  assign pend_o = pend_q;
  assign sval_o = sval_q;
  assign ssrc_o = ssrc_q;
endmodule

// File: rtl/fwd_unit.sv
// One processing unit's forwarding state and its outgoing ring link.
module fwd_unit #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 16,
  parameter int UNIT_ID   = 0,
  localparam int RW   = fwd_ring_pkg::idx_w(NUM_REGS),
  localparam int UW   = fwd_ring_pkg::idx_w(NUM_UNITS),
  localparam int NEXT = fwd_ring_pkg::ring_next(UNIT_ID, NUM_UNITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_vld,
  input  logic [NUM_REGS-1:0] start_create,
  input  logic [NUM_REGS-1:0] start_keep,
  input  logic                wr_vld,
  input  logic                wr_fwd,
  input  logic [RW-1:0]       wr_reg,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rel_vld,
  input  logic [RW-1:0]       rel_reg,
  input  logic                squash,
  input  logic [RW-1:0]       rd_reg,
  output logic                rd_ok,
  input  logic                in_vld,
  input  logic [RW-1:0]       in_reg,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [UW-1:0]       in_src,
  output logic                out_vld,
  output logic [RW-1:0]       out_reg,
  output logic [DATA_W-1:0]   out_data,
  output logic [UW-1:0]       out_src,
  output logic [NUM_REGS-1:0] ready
);
  logic [NUM_REGS-1:0] pend_v;
  logic [DATA_W-1:0]   sval_a [NUM_REGS];
  logic [UW-1:0]       ssrc_a [NUM_REGS];
  logic                sel_vld;
  logic [RW-1:0]       sel_idx;
  logic                pass_ok;

  assign pass_ok = (in_src != UW'(NEXT));

  fwd_pick #(.N(NUM_REGS)) u_pick (
    .req (pend_v),
    .vld (sel_vld),
    .idx (sel_idx)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_slot
    fwd_slot #(.DATA_W(DATA_W), .UNIT_W(UW), .UNIT_ID(UNIT_ID)) u_slot (
      .clk          (clk),
      .rst          (rst),
      .squash       (squash),
      .start_vld    (start_vld),
      .start_create (start_create[r]),
      .start_keep   (start_keep[r]),
      .hit_arr      (in_vld && (in_reg == RW'(r))),
      .arr_data     (in_data),
      .arr_src      (in_src),
      .arr_pass_ok  (pass_ok),
      .hit_wr       (wr_vld && wr_fwd && (wr_reg == RW'(r))),
      .wr_data      (wr_data),
      .hit_rel      (rel_vld && (rel_reg == RW'(r))),
      .sent         (sel_vld && (sel_idx == RW'(r))),
      .rdy_o        (ready[r]),
      .pend_o       (pend_v[r]),
      .sval_o       (sval_a[r]),
      .ssrc_o       (ssrc_a[r])
    );
  end

  assign out_vld  = sel_vld;
  assign out_reg  = sel_idx;
  assign out_data = sval_a[sel_idx];
  assign out_src  = ssrc_a[sel_idx];
  assign rd_ok    = ready[rd_reg];
endmodule

// File: rtl/fwd_ring.sv
// Ring of forwarding units; unit u listens to the link of unit u-1.
module fwd_ring #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 16,
  localparam int RW = fwd_ring_pkg::idx_w(NUM_REGS),
  localparam int UW = fwd_ring_pkg::idx_w(NUM_UNITS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_UNITS-1:0]          start_vld,
  input  logic [NUM_UNITS*NUM_REGS-1:0] start_create,
  input  logic [NUM_UNITS*NUM_REGS-1:0] start_keep,
  input  logic [NUM_UNITS-1:0]          wr_vld,
  input  logic [NUM_UNITS-1:0]          wr_fwd,
  input  logic [NUM_UNITS*RW-1:0]       wr_reg,
  input  logic [NUM_UNITS*DATA_W-1:0]   wr_data,
  input  logic [NUM_UNITS-1:0]          rel_vld,
  input  logic [NUM_UNITS*RW-1:0]       rel_reg,
  input  logic [NUM_UNITS-1:0]          squash,
  input  logic [NUM_UNITS*RW-1:0]       rd_reg,
  output logic [NUM_UNITS-1:0]          rd_ok,
  output logic [NUM_UNITS-1:0]          ring_vld,
  output logic [NUM_UNITS*RW-1:0]       ring_reg,
  output logic [NUM_UNITS*DATA_W-1:0]   ring_data,
  output logic [NUM_UNITS*UW-1:0]       ring_src,
  output logic [NUM_UNITS*NUM_REGS-1:0] reg_ready
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam int P = fwd_ring_pkg::ring_prev(u, NUM_UNITS);
    fwd_unit #(
      .NUM_UNITS (NUM_UNITS),
      .NUM_REGS  (NUM_REGS),
      .DATA_W    (DATA_W),
      .UNIT_ID   (u)
    ) u_unit (
      .clk          (clk),
      .rst          (rst),
      .start_vld    (start_vld[u]),
      .start_create (start_create[u*NUM_REGS +: NUM_REGS]),
      .start_keep   (start_keep[u*NUM_REGS +: NUM_REGS]),
      .wr_vld       (wr_vld[u]),
      .wr_fwd       (wr_fwd[u]),
      .wr_reg       (wr_reg[u*RW +: RW]),
      .wr_data      (wr_data[u*DATA_W +: DATA_W]),
      .rel_vld      (rel_vld[u]),
      .rel_reg      (rel_reg[u*RW +: RW]),
      .squash       (squash[u]),
      .rd_reg       (rd_reg[u*RW +: RW]),
      .rd_ok        (rd_ok[u]),
      .in_vld       (ring_vld[P]),
      .in_reg       (ring_reg[P*RW +: RW]),
      .in_data      (ring_data[P*DATA_W +: DATA_W]),
      .in_src       (ring_src[P*UW +: UW]),
      .out_vld      (ring_vld[u]),
      .out_reg      (ring_reg[u*RW +: RW]),
      .out_data     (ring_data[u*DATA_W +: DATA_W]),
      .out_src      (ring_src[u*UW +: UW]),
      .ready        (reg_ready[u*NUM_REGS +: NUM_REGS])
    );
  end
endmodule

// File: rtl/fwd_ring_chk.sv
module fwd_ring_chk #(
  parameter int NUM_UNITS = 4,
  parameter int NUM_REGS  = 8,
  localparam int RW = fwd_ring_pkg::idx_w(NUM_REGS),
  localparam int UW = fwd_ring_pkg::idx_w(NUM_UNITS)
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_UNITS-1:0]          start_vld,
  input logic [NUM_UNITS*NUM_REGS-1:0] start_keep,
  input logic [NUM_UNITS-1:0]          squash,
  input logic [NUM_UNITS-1:0]          ring_vld,
  input logic [NUM_UNITS*RW-1:0]       ring_reg,
  input logic [NUM_UNITS*UW-1:0]       ring_src,
  input logic [NUM_UNITS*NUM_REGS-1:0] reg_ready
);
  logic [RW-1:0] hop_q [NUM_UNITS];

  always_ff @(posedge clk) begin
    for (int u = 0; u < NUM_UNITS; u++) hop_q[u] <= ring_reg[u*RW +: RW];
  end

  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ring_vld == '0 && reg_ready == '0));

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
    localparam int N = fwd_ring_pkg::ring_next(u, NUM_UNITS);
    localparam int P = fwd_ring_pkg::ring_prev(u, NUM_UNITS);

    // R4
    hop_arrives_chk: assert property (@(posedge clk) disable iff (rst)
      (ring_vld[u] && !squash[N]) |=> reg_ready[N*NUM_REGS + int'(hop_q[u])]);

    // R5
    no_return_chk: assert property (@(posedge clk) disable iff (rst)
      ring_vld[u] |-> (ring_src[u*UW +: UW] != UW'(N)));

    // R9
    squash_wipe_chk: assert property (@(posedge clk) disable iff (rst)
      squash[u] |=> (reg_ready[u*NUM_REGS +: NUM_REGS] == '0 && !ring_vld[u]));

    // R2
    start_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (start_vld[u] && !squash[u] && !ring_vld[P]) |=>
        ((reg_ready[u*NUM_REGS +: NUM_REGS] &
          ~$past(start_keep[u*NUM_REGS +: NUM_REGS])) == '0));
  end
endmodule

bind fwd_ring fwd_ring_chk #(.NUM_UNITS(NUM_UNITS), .NUM_REGS(NUM_REGS)) u_fwd_ring_chk (
  .clk        (clk),
  .rst        (rst),
  .start_vld  (start_vld),
  .start_keep (start_keep),
  .squash     (squash),
  .ring_vld   (ring_vld),
  .ring_reg   (ring_reg),
  .ring_src   (ring_src),
  .reg_ready  (reg_ready)
);

// File: tb/fwd_ring_test.sv
module fwd_ring_test;
  localparam int U = 4, R = 8, DW = 16, RW = 3, UW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [U-1:0]    start_vld = '0, wr_vld = '0, wr_fwd = '0, rel_vld = '0, squash = '0;
  logic [U*R-1:0]  start_create = '0, start_keep = '0;
  logic [U*RW-1:0] wr_reg = '0, rel_reg = '0, rd_reg = '0;
  logic [U*DW-1:0] wr_data = '0;
  logic [U-1:0]    rd_ok, ring_vld;
  logic [U*RW-1:0] ring_reg;
  logic [U*DW-1:0] ring_data;
  logic [U*UW-1:0] ring_src;
  logic [U*R-1:0]  reg_ready;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fwd_ring #(.NUM_UNITS(U), .NUM_REGS(R), .DATA_W(DW)) uut (.*);

  // Vector: [31:30] source unit, [29:28] holding unit (= source: none),
  // [26:24] register, [15:0] data.
  localparam logic [31:0] VEC [4] = '{
    {2'd0, 2'd0, 1'b0, 3'd1, 8'h00, 16'h1111},
    {2'd2, 2'd3, 1'b0, 3'd7, 8'h00, 16'hBEEF},
    {2'd1, 2'd3, 1'b0, 3'd0, 8'h00, 16'h0A5A},
    {2'd3, 2'd1, 1'b0, 3'd5, 8'h00, 16'h7E57}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_msg(input int u, input int r, input int d, input int s, input string req);
    chk(ring_vld[u] == 1'b1, req, 32'(ring_vld[u]), 1);
    chk(ring_reg[u*RW +: RW] == RW'(r) && ring_data[u*DW +: DW] == DW'(d) &&
        ring_src[u*UW +: UW] == UW'(s), req,
        {13'd0, ring_reg[u*RW +: RW], ring_data[u*DW +: DW]}, 32'((r << 16) | d));
  endtask

  task automatic clear_in();
    start_vld = '0; wr_vld = '0; wr_fwd = '0; rel_vld = '0; squash = '0;
  endtask

  task automatic write(input int u, input int r, input int d, input bit fwd);
    wr_vld[u] = 1'b1; wr_fwd[u] = fwd;
    wr_reg[u*RW +: RW] = RW'(r); wr_data[u*DW +: DW] = DW'(d);
  endtask

  task automatic release_reg(input int u, input int r);
    rel_vld[u] = 1'b1; rel_reg[u*RW +: RW] = RW'(r);
  endtask

  // Squash every unit, then start all with the given create masks.
  task automatic restart(input logic [U*R-1:0] masks);
    squash = '1; tick(); clear_in();
    start_vld = '1; start_create = masks; start_keep = '0;
    tick(); clear_in();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(reg_ready == '0, "R1 ready", reg_ready, 0);
    chk(ring_vld == '0, "R1 links", 32'(ring_vld), 0);

    // Table: one forward write, follow it hop by hop (R4, R5, R6).
    for (int i = 0; i < 4; i++) begin
      int s, stop, r, d, cur, nxt;
      logic [U*R-1:0] m;
      s = int'(VEC[i][31:30]); stop = int'(VEC[i][29:28]);
      r = int'(VEC[i][26:24]); d = int'(VEC[i][15:0]);
      m = '0; m[s*R + r] = 1'b1; m[stop*R + r] = 1'b1;
      restart(m);
      write(s, r, d, 1'b1); tick(); clear_in();
      cur = s;
      for (int h = 0; h < U; h++) begin
        chk_msg(cur, r, d, s, "R4/R5 message on link");
        nxt = (cur + 1) % U;
        tick();
        chk(reg_ready[nxt*R + r] == 1'b1, "R4 successor ready", 32'(reg_ready[nxt*R + r]), 1);
        if (nxt == stop || (nxt + 1) % U == s) begin
          chk(ring_vld == '0, "R5/R6 relay stops", 32'(ring_vld), 0);
          break;
        end
        cur = nxt;
      end
      chk(reg_ready[s*R + r] == 1'b0, "R5 no return to source", 32'(reg_ready[s*R + r]), 0);
    end

    // R10 / R4: writes without forward flag, and events on uncreated registers.
    restart(32'h0000_0008);
    write(0, 3, 16'h5555, 1'b0); write(3, 3, 16'h6666, 1'b1); release_reg(1, 5);
    tick(); clear_in();
    chk(ring_vld == '0, "R10 R4 no message", 32'(ring_vld), 0);
    tick(); tick();
    chk(reg_ready == '0, "R10 nothing arrived", reg_ready, 0);

    // R2 / R3 / R7: start with keep, then release the kept value.
    write(0, 3, 16'hA1A1, 1'b1); tick(); clear_in();
    repeat (4) tick();
    chk(reg_ready[1*R + 3] && reg_ready[2*R + 3] && reg_ready[3*R + 3], "R5 relayed to all",
        {reg_ready[3*R+3], reg_ready[2*R+3], reg_ready[1*R+3]}, 7);
    start_vld[1] = 1'b1; start_create[1*R +: R] = '0; start_keep[1*R +: R] = '0;
    start_vld[2] = 1'b1; start_create[2*R +: R] = 8'h08; start_keep[2*R +: R] = 8'h08;
    tick(); clear_in();
    chk(reg_ready[1*R + 3] == 1'b0, "R2 cleared", 32'(reg_ready[1*R + 3]), 0);
    chk(reg_ready[2*R + 3] == 1'b1, "R2 kept", 32'(reg_ready[2*R + 3]), 1);
    rd_reg[2*RW +: RW] = 3'd3; rd_reg[1*RW +: RW] = 3'd3; #1;
    chk(rd_ok[2] == 1'b1, "R3 read allowed", 32'(rd_ok[2]), 1);
    chk(rd_ok[1] == 1'b0, "R3 read stalls", 32'(rd_ok[1]), 0);
    release_reg(2, 3); tick(); clear_in();
    chk_msg(2, 3, 16'hA1A1, 2, "R7 release sends kept value");

    // R7: release before the value arrives.
    restart(32'h0000_1010);
    release_reg(1, 4); tick(); clear_in();
    chk(ring_vld[1] == 1'b0, "R7 release waits", 32'(ring_vld[1]), 0);
    write(0, 4, 16'hB2B2, 1'b1); tick(); clear_in();
    chk_msg(0, 4, 16'hB2B2, 0, "R4 origin link");
    tick();
    chk_msg(1, 4, 16'hB2B2, 1, "R7 late release goes out");

    // R6 / R8: held value, then two pending sends, lowest register first.
    restart(32'h0400_0044);
    write(3, 2, 16'hC3C3, 1'b1); tick(); clear_in(); tick();
    chk(reg_ready[0*R + 2] == 1'b1, "R6 held value ready", 32'(reg_ready[2]), 1);
    chk(ring_vld[0] == 1'b0, "R6 held not relayed", 32'(ring_vld[0]), 0);
    release_reg(0, 2); write(0, 6, 16'hD4D4, 1'b1); tick(); clear_in();
    chk_msg(0, 2, 16'hC3C3, 0, "R8 lower register first");
    tick();
    chk_msg(0, 6, 16'hD4D4, 0, "R8 higher register next");

    // R9 / R3: squash drops a waiting send and clears ready bits.
    restart(32'h0400_0004);
    write(3, 2, 16'hE5E5, 1'b1); tick(); clear_in(); tick();
    rd_reg[0 +: RW] = 3'd2; #1;
    chk(rd_ok[0] == 1'b1, "R3 ready before squash", 32'(rd_ok[0]), 1);
    release_reg(0, 2); squash[0] = 1'b1; tick(); clear_in();
    chk(ring_vld[0] == 1'b0, "R9 send dropped", 32'(ring_vld[0]), 0);
    chk(reg_ready[0 +: R] == '0, "R9 ready cleared", 32'(reg_ready[0 +: R]), 0);
    chk(rd_ok[0] == 1'b0, "R3 stalls after squash", 32'(rd_ok[0]), 0);
    tick();
    chk(ring_vld == '0, "R9 ring quiet", 32'(ring_vld), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule